// File: doc/BRIEF.md
# Peripheral Enumeration Register Interface

This block lets a host discover, one at a time, the peripherals in a fixed table supplied at its inputs. Each table entry carries six 32-bit fields: name length, identifier, base address, window size, first interrupt line and interrupt count. The host reaches the block through a 32-bit register port. The block keeps a cursor into the table and one "already reported" flag per entry. It raises one level interrupt while there are entries left to announce.

The host starts an enumeration by writing zero to the operation register. Each read of that register then retires the current entry and moves the cursor to the next entry that has not been reported yet. The field registers show that entry, and a write to the name-fetch register asks an external memory-write agent to copy the entry's name to a host address. The walk skips reported entries at one entry per clock cycle, so the request channel deasserts ready while it runs.

The request channel is valid/ready: a request is taken on a clock edge where both are high, and the host must hold address, direction and data stable while valid waits for ready. Read responses come back as a one-cycle pulse on `rsp_valid` and have no back-pressure. The copy request to the memory agent is also valid/ready: the block holds it, with stable address and length, until the agent raises ready.

Top module: `periph_enum_regs`

## Requirements
- R1: After reset the cursor is empty, all reported flags are clear, `irq_o`, `err_o`, `host64_o` and `cp_valid` are low, the upper address latch is zero and `req_ready` is high.
- R2: A read of the operation register (offset 0x00) returns 0x08 when the cursor lands on an unreported entry and 0x00 when no entry is left. The 0x00 outcome drives `irq_o` low.
- R3: On an operation read with a valid cursor, the current entry's reported flag is set and the search starts at the next index. With an empty cursor the search starts at index 0. The search passes over every entry whose flag is set and stops at index `tbl_count`.
- R4: Reads of name length (0x08), identifier (0x0C), base (0x10), size (0x14), first interrupt (0x18) and interrupt count (0x1C) return the current entry's field, or zero when the cursor is empty.
- R5: Writing 0x00 to offset 0x00 clears every reported flag and empties the cursor. It sets `irq_o` high if `tbl_count` is non-zero and low otherwise.
- R6: A write to offset 0x20 stores the value as bits 63:32 of the copy address and sets `host64_o`, which stays high until reset.
- R7: A write to offset 0x04 with a valid cursor issues a copy request with `cp_addr` = {upper latch, written word} and `cp_len` = the current entry's name length. With an empty cursor the write has no effect and raises no error.
- R8: A copy request stays asserted, with `cp_addr` and `cp_len` unchanged, until a cycle with `cp_ready` high.
- R9: A name-fetch write taken while a copy request is outstanding is dropped (the pending request is unchanged) and sets `err_o`.
- R10: A read of an undefined offset or of a write-only register (0x04, 0x20), a write to an undefined offset or to a read-only register (0x08 to 0x1C), and an operation write of any value other than 0x00 all set the sticky `err_o`. Such reads return zero.
- R11: The skip examines one table entry per cycle while `req_ready` is low. A field or error read responds in the cycle after acceptance, and an operation read responds one cycle after the last entry is examined.
- R12: `tbl_count` may grow between walks. Entries added after the walk reached its end are found by the next operation read, which passes over the entries already reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| tbl_count | input | CNT_W | Number of populated entries (clamped to N_ENTRIES) |
| tbl_name_len | input | 32*N_ENTRIES | Name length per entry, entry i at bits 32i+31:32i |
| tbl_id | input | 32*N_ENTRIES | Identifier per entry |
| tbl_base | input | 32*N_ENTRIES | Base address per entry |
| tbl_size | input | 32*N_ENTRIES | Window size per entry |
| tbl_irq | input | 32*N_ENTRIES | First interrupt line per entry |
| tbl_irq_cnt | input | 32*N_ENTRIES | Interrupt count per entry |
| irq_o | output | 1 | Entries-pending interrupt (level) |
| err_o | output | 1 | Sticky illegal-access flag |
| host64_o | output | 1 | Sticky flag: upper address word was written |
| cp_valid | output | 1 | Name-copy request valid |
| cp_ready | input | 1 | Memory agent accepts the copy request |
| cp_addr | output | 64 | Copy destination address |
| cp_len | output | 32 | Copy length in bytes |

## Verification
On every cycle the assertions check these properties: a retired entry's flag is set, a found entry was unreported, the scan index rises by one per busy cycle and the walk stays within the table length, and the walk outcome turns into the right response code. They also check that a pending copy holds still, that error and 64-bit flags are sticky, that the interrupt follows an init write, and that illegal or empty-cursor reads answer zero. Only the bench scenarios can show that whole walks visit entries in table order. The same holds for the hot-add skip, for the latency of a walk as a function of how many reported entries it passes, and for the field values seen for each entry. The bench's reference model also covers arbitrary interleavings of init, walk, fetch, acknowledge, count changes and illegal accesses.

// File: rtl/periph_enum_pkg.sv
package periph_enum_pkg;
  localparam int WORD_W = 32;

  // register byte offsets
  localparam int OFF_OP    = 'h00;
  localparam int OFF_FETCH = 'h04;
  localparam int OFF_NLEN  = 'h08;
  localparam int OFF_ID    = 'h0C;
  localparam int OFF_BASE  = 'h10;
  localparam int OFF_SIZE  = 'h14;
  localparam int OFF_IRQ   = 'h18;
  localparam int OFF_ICNT  = 'h1C;
  localparam int OFF_HI    = 'h20;

  localparam logic [WORD_W-1:0] CODE_ADD  = 32'h0000_0008;
  localparam logic [WORD_W-1:0] CODE_DONE = 32'h0000_0000;

  typedef enum logic [3:0] {
    SEL_OP, SEL_FETCH, SEL_NLEN, SEL_ID, SEL_BASE,
    SEL_SIZE, SEL_IRQ, SEL_ICNT, SEL_HI, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] name_len;
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] size;
    logic [WORD_W-1:0] irq_first;
    logic [WORD_W-1:0] irq_count;
  } entry_t;
endpackage

// File: rtl/pe_reg_decode.sv
module pe_reg_decode
  import periph_enum_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [WORD_W-1:0] wdata,
  output reg_sel_e          sel,
  output logic              bad
);
  always_comb begin
    if      (addr == ADDR_W'(OFF_OP))    sel = SEL_OP;
    else if (addr == ADDR_W'(OFF_FETCH)) sel = SEL_FETCH;
    else if (addr == ADDR_W'(OFF_NLEN))  sel = SEL_NLEN;
    else if (addr == ADDR_W'(OFF_ID))    sel = SEL_ID;
    else if (addr == ADDR_W'(OFF_BASE))  sel = SEL_BASE;
    else if (addr == ADDR_W'(OFF_SIZE))  sel = SEL_SIZE;
    else if (addr == ADDR_W'(OFF_IRQ))   sel = SEL_IRQ;
    else if (addr == ADDR_W'(OFF_ICNT))  sel = SEL_ICNT;
    else if (addr == ADDR_W'(OFF_HI))    sel = SEL_HI;
    else                                 sel = SEL_NONE;
  end

  // legality of the access given its direction (R10)
  always_comb begin
    case (sel)
      SEL_NONE:            bad = 1'b1;
      SEL_OP:              bad = write && (wdata != '0);
      SEL_FETCH, SEL_HI:   bad = !write;
      default:             bad = write;
    endcase
  end
endmodule

// File: rtl/pe_cursor_walk.sv
module pe_cursor_walk #(
  parameter int N_ENTRIES = 4,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CNT_W = $clog2(N_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic [CNT_W-1:0] count,
  output logic             cur_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic             busy,
  output logic             done,
  output logic             found
);
  logic [N_ENTRIES-1:0] flags;
  logic [CNT_W-1:0]     scan;
  logic                 scan_end;
  logic                 scan_hit;

  assign scan_end = (scan >= count);
  assign scan_hit = flags[scan[IDX_W-1:0]];
  assign done     = busy && (scan_end || !scan_hit);
  assign found    = busy && !scan_end && !scan_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      cur_valid <= 1'b0;
      cur_idx   <= '0;
      busy      <= 1'b0;
      scan      <= '0;
    end else if (clear) begin
      flags     <= '0;
      cur_valid <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      if (cur_valid) begin
        flags[cur_idx] <= 1'b1;
        scan           <= CNT_W'(cur_idx) + CNT_W'(1);
      end else begin
        scan <= '0;
      end
    end else if (busy) begin
      if (scan_end) begin
        cur_valid <= 1'b0;
        busy      <= 1'b0;
      end else if (scan_hit) begin
        scan <= scan + CNT_W'(1);
      end else begin
        cur_idx   <= scan[IDX_W-1:0];
        cur_valid <= 1'b1;
        busy      <= 1'b0;
      end
    end
  end

  // walk length watch for R11
  logic [CNT_W:0] busy_cycles;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cycles <= '0;
    else                 busy_cycles <= busy_cycles + 1'b1;
  end

  a_r3_retire_marks: assert property (@(posedge clk) disable iff (!rst_n)
    start && cur_valid && !clear |=> flags[$past(cur_idx)]);
  a_r3_found_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> cur_valid && !busy && !flags[cur_idx]);
  a_r11_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && (scan == $past(scan) + CNT_W'(1)));
  a_r11_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cycles <= (CNT_W + 1)'(N_ENTRIES + 1));
endmodule

// File: rtl/pe_copy_req.sv
module pe_copy_req
  import periph_enum_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [2*WORD_W-1:0] addr_in,
  input  logic [WORD_W-1:0]   len_in,
  input  logic                ack,
  output logic                cp_valid,
  output logic [2*WORD_W-1:0] cp_addr,
  output logic [WORD_W-1:0]   cp_len,
  output logic                drop
);
  assign drop = fire && cp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_valid <= 1'b0;
      cp_addr  <= '0;
      cp_len   <= '0;
    end else begin
      if (cp_valid && ack) cp_valid <= 1'b0;
      if (fire && !cp_valid) begin
        cp_valid <= 1'b1;
        cp_addr  <= addr_in;
        cp_len   <= len_in;
      end
    end
  end

  a_r7_issue: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cp_valid |=> cp_valid && cp_addr == $past(addr_in) && cp_len == $past(len_in));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && !ack |=> cp_valid && $stable(cp_addr) && $stable(cp_len));
  a_r9_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !ack |=> $stable(cp_addr) && $stable(cp_len));
endmodule

// File: rtl/periph_enum_regs.sv
module periph_enum_regs
  import periph_enum_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CNT_W = $clog2(N_ENTRIES + 1),
  localparam int TBL_W = N_ENTRIES * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  input  logic [CNT_W-1:0]    tbl_count,
  input  logic [TBL_W-1:0]    tbl_name_len,
  input  logic [TBL_W-1:0]    tbl_id,
  input  logic [TBL_W-1:0]    tbl_base,
  input  logic [TBL_W-1:0]    tbl_size,
  input  logic [TBL_W-1:0]    tbl_irq,
  input  logic [TBL_W-1:0]    tbl_irq_cnt,
  output logic                irq_o,
  output logic                err_o,
  output logic                host64_o,
  output logic                cp_valid,
  input  logic                cp_ready,
  output logic [2*WORD_W-1:0] cp_addr,
  output logic [WORD_W-1:0]   cp_len
);
  reg_sel_e sel;
  logic     bad;

  pe_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .write(req_write),
    .wdata(req_wdata),
    .sel  (sel),
    .bad  (bad)
  );

  logic acc, acc_rd, acc_wr, acc_op_rd, acc_init, acc_fetch, acc_hi;
  assign acc       = req_valid && req_ready;
  assign acc_rd    = acc && !req_write;
  assign acc_wr    = acc && req_write;
  assign acc_op_rd = acc_rd && (sel == SEL_OP);
  assign acc_init  = acc_wr && (sel == SEL_OP) && !bad;
  assign acc_fetch = acc_wr && (sel == SEL_FETCH);
  assign acc_hi    = acc_wr && (sel == SEL_HI);

  logic [CNT_W-1:0] eff_count;
  assign eff_count = (tbl_count > CNT_W'(N_ENTRIES)) ? CNT_W'(N_ENTRIES) : tbl_count;

  logic             cur_valid;
  logic [IDX_W-1:0] cur_idx;
  logic             walk_busy, walk_done, walk_found;

  pe_cursor_walk #(.N_ENTRIES(N_ENTRIES)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc_op_rd),
    .clear    (acc_init),
    .count    (eff_count),
    .cur_valid(cur_valid),
    .cur_idx  (cur_idx),
    .busy     (walk_busy),
    .done     (walk_done),
    .found    (walk_found)
  );

  assign req_ready = !walk_busy;

  // table unpacking
  entry_t tbl_e [N_ENTRIES];
  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_entry
    assign tbl_e[gi].name_len  = tbl_name_len[gi*WORD_W +: WORD_W];
    assign tbl_e[gi].id        = tbl_id      [gi*WORD_W +: WORD_W];
    assign tbl_e[gi].base      = tbl_base    [gi*WORD_W +: WORD_W];
    assign tbl_e[gi].size      = tbl_size    [gi*WORD_W +: WORD_W];
    assign tbl_e[gi].irq_first = tbl_irq     [gi*WORD_W +: WORD_W];
    assign tbl_e[gi].irq_count = tbl_irq_cnt [gi*WORD_W +: WORD_W];
  end

  entry_t            cur_e;
  logic [WORD_W-1:0] field_data;
  assign cur_e = tbl_e[cur_idx];

  always_comb begin
    case (sel)
      SEL_NLEN: field_data = cur_e.name_len;
      SEL_ID:   field_data = cur_e.id;
      SEL_BASE: field_data = cur_e.base;
      SEL_SIZE: field_data = cur_e.size;
      SEL_IRQ:  field_data = cur_e.irq_first;
      SEL_ICNT: field_data = cur_e.irq_count;
      default:  field_data = '0;
    endcase
    if (!cur_valid) field_data = '0;
  end

  // read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (acc_rd && (sel != SEL_OP)) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= bad ? '0 : field_data;
      end else if (walk_done) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= walk_found ? CODE_ADD : CODE_DONE;
      end
    end
  end

  // interrupt, flags and upper address latch
  logic [WORD_W-1:0] hi_word;
  logic              cp_drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      err_o    <= 1'b0;
      host64_o <= 1'b0;
      hi_word  <= '0;
    end else begin
      if (acc_init)                     irq_o <= (eff_count != '0);
      else if (walk_done && !walk_found) irq_o <= 1'b0;
      if ((acc && bad) || cp_drop)      err_o <= 1'b1;
      if (acc_hi) begin
        hi_word  <= req_wdata;
        host64_o <= 1'b1;
      end
    end
  end

  pe_copy_req u_copy (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (acc_fetch && cur_valid),
    .addr_in ({hi_word, req_wdata}),
    .len_in  (cur_e.name_len),
    .ack     (cp_ready),
    .cp_valid(cp_valid),
    .cp_addr (cp_addr),
    .cp_len  (cp_len),
    .drop    (cp_drop)
  );

  a_r2_done_code: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid && rsp_rdata == ($past(walk_found) ? CODE_ADD : CODE_DONE));
  a_r2_end_lowers_irq: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done && !walk_found |=> !irq_o);
  a_r5_init_irq: assert property (@(posedge clk) disable iff (!rst_n)
    acc_init |=> irq_o == $past(eff_count != '0) && !cur_valid);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  a_r6_host64_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    host64_o |=> host64_o);
  a_r10_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && bad |=> rsp_valid && rsp_rdata == '0 && err_o);
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && (sel != SEL_OP) && !cur_valid |=> rsp_valid && rsp_rdata == '0);
  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> !rsp_valid || !$past(acc));
endmodule

// File: tb/periph_enum_regs_test.sv
module periph_enum_regs_test;
  localparam int N   = 4;
  localparam int CW  = $clog2(N + 1);
  localparam int TW  = N * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          req_valid = 0, req_write = 0, cp_ready = 0;
  logic [7:0]    req_addr = 0;
  logic [31:0]   req_wdata = 0;
  logic [CW-1:0] tbl_count = 0;
  logic [TW-1:0] t_nl, t_id, t_base, t_sz, t_irq, t_ic;
  logic          req_ready, rsp_valid, irq_o, err_o, host64_o, cp_valid;
  logic [31:0]   rsp_rdata, cp_len;
  logic [63:0]   cp_addr;

  periph_enum_regs #(.N_ENTRIES(N), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tbl_count(tbl_count), .tbl_name_len(t_nl), .tbl_id(t_id), .tbl_base(t_base),
    .tbl_size(t_sz), .tbl_irq(t_irq), .tbl_irq_cnt(t_ic),
    .irq_o(irq_o), .err_o(err_o), .host64_o(host64_o),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_addr(cp_addr), .cp_len(cp_len)
  );

  int checks = 0, errors = 0, cyc = 0;

  // reference model
  logic        m_flag [N];
  logic        m_cv, m_irq, m_err, m_h64, m_pend;
  int          m_ci, m_cnt;
  logic [31:0] m_hi;
  logic [63:0] m_paddr;
  logic [31:0] m_plen;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(input int off, input int idx);
    case (off)
      'h08: return t_nl [idx*32 +: 32];
      'h0C: return t_id [idx*32 +: 32];
      'h10: return t_base[idx*32 +: 32];
      'h14: return t_sz [idx*32 +: 32];
      'h18: return t_irq[idx*32 +: 32];
      default: return t_ic[idx*32 +: 32];
    endcase
  endfunction

  function automatic logic [31:0] exp_field(input int off);
    return m_cv ? fld(off, m_ci) : 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_flag[i] = 0;
    m_cv = 0; m_ci = 0; m_irq = 0; m_err = 0; m_h64 = 0; m_pend = 0;
    m_hi = 0; m_paddr = 0; m_plen = 0;
  endtask

  task automatic m_op(output logic [31:0] code, output int lat);
    int s;
    if (m_cv) begin m_flag[m_ci] = 1; s = m_ci + 1; end else s = 0;
    lat = 2;
    while (s < m_cnt && m_flag[s]) begin s++; lat++; end
    if (s < m_cnt) begin m_ci = s; m_cv = 1; code = 32'h8; end
    else begin m_cv = 0; m_irq = 0; code = 32'h0; end
  endtask

  task automatic m_init();
    for (int i = 0; i < N; i++) m_flag[i] = 0;
    m_cv = 0; m_irq = (m_cnt != 0);
  endtask

  task automatic m_fetch(input logic [31:0] lo);
    if (m_cv) begin
      if (m_pend) m_err = 1;
      else begin m_pend = 1; m_paddr = {m_hi, lo}; m_plen = fld('h08, m_ci); end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req_valid = 0; cp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic set_count(input int c);
    @(negedge clk); tbl_count = CW'(c); m_cnt = c;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 0;
    end while (!rsp_valid && lat < 64);
    d = rsp_rdata;
  endtask

  task automatic do_ack();
    @(negedge clk); cp_ready = 1;
    @(negedge clk); cp_ready = 0;
    m_pend = 0;
  endtask

  task automatic chk_state(input string tag);
    chk(irq_o == m_irq, {tag, " irq"}, 64'(irq_o), 64'(m_irq));
    chk(err_o == m_err, {tag, " err"}, 64'(err_o), 64'(m_err));
    chk(host64_o == m_h64, {tag, " host64"}, 64'(host64_o), 64'(m_h64));
    chk(cp_valid == m_pend, {tag, " cp_valid"}, 64'(cp_valid), 64'(m_pend));
    if (m_pend) begin
      chk(cp_addr == m_paddr, {tag, " cp_addr"}, cp_addr, m_paddr);
      chk(cp_len == m_plen, {tag, " cp_len"}, 64'(cp_len), 64'(m_plen));
    end
  endtask

  task automatic op_read(input string tag);
    logic [31:0] d, e; int lat, el;
    do_rd(8'h00, d, lat);
    m_op(e, el);
    chk(d == e, {tag, " op code"}, 64'(d), 64'(e));
    chk(lat == el, {tag, " R11 walk latency"}, 64'(lat), 64'(el));
  endtask

  task automatic field_read(input int off, input string tag);
    logic [31:0] d, e; int lat;
    do_rd(8'(off), d, lat);
    e = exp_field(off);
    chk(d == e, {tag, " field"}, 64'(d), 64'(e));
    chk(lat == 1, {tag, " R11 read latency"}, 64'(lat), 64'd1);
  endtask

  task automatic bad_access(input int kind);
    logic [31:0] d; int lat;
    case (kind)
      0: begin do_rd(8'h24, d, lat); chk(d == 0, "R10 undefined read zero", 64'(d), 0); end
      1: begin do_rd(8'h04, d, lat); chk(d == 0, "R10 fetch read zero", 64'(d), 0); end
      2: begin do_rd(8'h20, d, lat); chk(d == 0, "R10 upper read zero", 64'(d), 0); end
      3: do_wr(8'h0C, 32'h1234);
      4: do_wr(8'h00, 32'h5);
      default: do_wr(8'h02, 32'h1);
    endcase
    m_err = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; int lat;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) begin
      t_nl [i*32 +: 32] = 32'd3 + 32'($urandom_range(0, 60));
      t_id [i*32 +: 32] = 32'h100 + 32'(i) * 7;
      t_base[i*32 +: 32] = 32'h1000_0000 + 32'(i) * 32'h1000;
      t_sz [i*32 +: 32] = 32'h1000 << i;
      t_irq[i*32 +: 32] = 32'd4 + 32'(i) * 2;
      t_ic [i*32 +: 32] = 32'd1 + 32'(i % 2);
    end
    m_cnt = 0;
    do_reset();

    // R1 reset state
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", 64'(req_ready), 1);
    chk_state("R1 reset");
    field_read('h0C, "R1 R4 empty cursor id");
    field_read('h08, "R4 empty cursor name length");

    // R2 R3 R4 full walk over three entries
    set_count(3);
    do_wr(8'h00, 0); m_init();
    chk_state("R5 init");
    for (int k = 0; k < 3; k++) begin
      op_read("R2 R3 walk step");
      for (int off = 'h08; off <= 'h1C; off += 4) field_read(off, "R4 entry field");
      chk_state("R3 mid walk");
    end
    op_read("R2 walk end");
    chk_state("R2 irq low at end");
    field_read('h10, "R4 empty after end");
    op_read("R3 all reported");
    do_wr(8'h00, 0); m_init();
    op_read("R5 flags cleared restart");
    field_read('h0C, "R5 first entry again");

    // R5 empty table keeps irq low
    set_count(0);
    do_wr(8'h00, 0); m_init();
    chk_state("R5 empty table irq");
    op_read("R2 empty table done");

    // R12 hot add: skip reported entries
    set_count(2);
    do_wr(8'h00, 0); m_init();
    op_read("R12 a"); op_read("R12 b"); op_read("R12 end");
    set_count(4);
    op_read("R12 skip to added entry");
    field_read('h0C, "R12 added entry id");
    op_read("R12 last added");
    op_read("R12 end again");

    // R6 R7 R8 R9 copy request
    do_reset();
    set_count(3);
    do_wr(8'h00, 0); m_init();
    op_read("R7 prep");
    do_wr(8'h20, 32'hA5A5_0001); m_hi = 32'hA5A5_0001; m_h64 = 1;
    chk_state("R6 upper latch");
    do_wr(8'h04, 32'h0000_4000); m_fetch(32'h0000_4000);
    chk_state("R7 copy issued");
    repeat (5) @(negedge clk);
    chk_state("R8 copy held");
    do_wr(8'h04, 32'h0000_8000); m_fetch(32'h0000_8000);
    chk_state("R9 second fetch dropped");
    do_ack();
    chk_state("R8 copy acked");

    // R7 fetch with empty cursor is ignored
    do_reset();
    set_count(3);
    do_wr(8'h04, 32'h0000_1000); m_fetch(32'h0000_1000);
    chk_state("R7 empty cursor ignored");
    do_wr(8'h20, 32'h0000_0007); m_hi = 32'h7; m_h64 = 1;
    do_wr(8'h00, 0); m_init();
    op_read("R7 walk");
    do_wr(8'h04, 32'h0000_2000); m_fetch(32'h0000_2000);
    chk_state("R7 copy with upper word");
    do_ack();

    // R10 illegal accesses, each from a clean reset
    for (int k = 0; k < 6; k++) begin
      do_reset();
      set_count(2);
      do_wr(8'h00, 0); m_init();
      bad_access(k);
      chk_state("R10 illegal access");
    end

    // random mix against the model
    do_reset();
    set_count(N);
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) op_read("R3 random op");
      else if (r < 52) field_read('h08 + 4 * $urandom_range(0, 5), "R4 random field");
      else if (r < 60) begin do_wr(8'h00, 0); m_init(); end
      else if (r < 70) begin
        logic [31:0] lo; lo = $urandom;
        do_wr(8'h04, lo); m_fetch(lo);
      end
      else if (r < 75) begin
        logic [31:0] hv; hv = $urandom;
        do_wr(8'h20, hv); m_hi = hv; m_h64 = 1;
      end
      else if (r < 85) do_ack();
      else if (r < 90) set_count($urandom_range(0, N));
      else if (r < 92) bad_access($urandom_range(0, 5));
      else @(negedge clk);
      chk_state("R2 R9 random state");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule